// File: doc/BRIEF.md
# Four-Way Vector Interleave Unit

This unit accepts four source vectors of `VL` bits each and builds four destination vectors from them. Destination `r` draws only on the r-th quarter of every source. It lays those elements out as groups of four, where each group holds one element from source 0, 1, 2 and 3 in that order. The element width is chosen per operation: 8, 16, 32 or 64 bits through a 2-bit size code, or 128 bits through a separate wide flag.

An operation enters through a valid/ready handshake, and the sources are latched at that moment. The unit then hands out the four destinations one beat at a time, each tagged with its index and a last flag. When the chosen width cannot be used with the configured vector length, or with the largest length the surrounding machine supports, the unit returns a single flagged error beat in place of data.

The controller is a three-state machine:
- `ST_IDLE`: waiting for input, with `in_ready` high.
- `ST_SEND`: streaming data beats.
- `ST_FAULT`: presenting the error beat.

Its transitions are:
- `ST_IDLE -> ST_SEND` on a legal accept.
- `ST_IDLE -> ST_FAULT` on an illegal accept.
- `ST_SEND -> ST_SEND` when beat 0, 1 or 2 is taken.
- `ST_SEND -> ST_IDLE` when beat 3 is taken.
- `ST_FAULT -> ST_IDLE` when the error beat is taken.

Top module: `vec_zip4`

## Requirements
- R1: The element width is 128 bits when `in_wide` is 1, whatever `in_size` holds. Otherwise it is 8 shifted left by `in_size`, so codes 0, 1, 2 and 3 give 8, 16, 32 and 64 bits.
- R2: Let E be the element width and Q = VL/(4·E). In destination r, element 4q+k (k = 0..3, q = 0..Q-1) equals element r·Q+q of source k. Element i occupies bits [i·E +: E]. Every element of every destination is written.
- R3: A legal operation produces exactly four beats carrying `out_idx` 0, 1, 2, 3 in that order. `out_last` is 1 only on the beat with index 3.
- R4: An operation whose element width satisfies VL < 4·E is illegal. It yields exactly one beat with `out_illegal` = 1, `out_last` = 1 and `out_data` = 0, and no data beat.
- R5: The operation is also illegal when E = 64 (size code 3, not wide) and `MAX_VL` < 256, and when E = 128 and `MAX_VL` < 512. Both cases are reported as in R4.
- R6: An operation is accepted only on a cycle where `in_valid` and `in_ready` are both 1. `in_ready` stays 0 from acceptance until the final beat of that operation has been taken with `out_valid` and `out_ready` both 1.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data`, `out_idx`, `out_last` and `out_illegal` hold their values into the next cycle.
- R8: Sources, size and wide flag are latched at acceptance. Changes on those inputs after acceptance have no effect on the beats of that operation.
- R9: After reset `out_valid` is 0 and `in_ready` is 1 on the first cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit can accept an operation |
| in_size | input | 2 | Element width code, width = 8 << code |
| in_wide | input | 1 | Selects 128-bit elements, overrides `in_size` |
| in_src0 | input | VL | Source vector 0 |
| in_src1 | input | VL | Source vector 1 |
| in_src2 | input | VL | Source vector 2 |
| in_src3 | input | VL | Source vector 3 |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Consumer takes the beat |
| out_data | output | VL | Destination vector, zero on an error beat |
| out_idx | output | 2 | Destination index of the beat |
| out_last | output | 1 | Final beat of the operation |
| out_illegal | output | 1 | Error beat: width not allowed |

## Verification
The bench sweeps every combination of size code and wide flag on a 128-bit configuration. This makes three widths legal and exercises both illegal paths. Each legal width is run with three source patterns:
- Patterns whose bytes encode their own source and position, so a misplaced element shows which source and index it came from.
- Single-bit patterns, which catch a lost or duplicated bit.
- Random words, which catch stuck or mixed lanes.

Runs alternate free flow with stalled beats to separate hold behaviour from data. Sources are inverted right after acceptance to show that the latched copy is used.

// File: rtl/zip4_pkg.sv
package zip4_pkg;

    typedef enum logic [2:0] {
        EW_8   = 3'd0,
        EW_16  = 3'd1,
        EW_32  = 3'd2,
        EW_64  = 3'd3,
        EW_128 = 3'd4
    } ew_code_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SEND  = 2'd1,
        ST_FAULT = 2'd2
    } zip_state_e;

    localparam int NUM_SRC = 4;
    localparam int NUM_EW  = 5;

    function automatic int ew_bits(ew_code_e c);
        return 8 << int'(c);
    endfunction

    function automatic logic ew_illegal(ew_code_e c, int vl, int max_vl);
        logic bad;
        bad = (vl < 4 * ew_bits(c));
        if (c == EW_64 && max_vl < 256) bad = 1'b1;
        if (c == EW_128 && max_vl < 512) bad = 1'b1;
        return bad;
    endfunction

endpackage

// File: rtl/zip4_permute.sv
module zip4_permute
    import zip4_pkg::*;
#(
    parameter int VL = 512
) (
    input  logic [VL-1:0] src0,
    input  logic [VL-1:0] src1,
    input  logic [VL-1:0] src2,
    input  logic [VL-1:0] src3,
    input  ew_code_e      ew,
    input  logic [1:0]    dst_idx,
    output logic [VL-1:0] dst
);
    logic [VL-1:0] srcs [NUM_SRC];
    logic [VL-1:0] per_w [NUM_EW];

    assign srcs[0] = src0;
    assign srcs[1] = src1;
    assign srcs[2] = src2;
    assign srcs[3] = src3;

    for (genvar wi = 0; wi < NUM_EW; wi++) begin : g_w
        localparam int W     = 8 << wi;
        localparam int QUADS = VL / (4 * W);
        if (QUADS > 0) begin : g_ok
            for (genvar q = 0; q < QUADS; q++) begin : g_q
                for (genvar k = 0; k < NUM_SRC; k++) begin : g_k
                    int base;
                    always_comb base = (int'(dst_idx) * QUADS + q) * W;
                    assign per_w[wi][(4*q+k)*W +: W] = srcs[k][base +: W];
                end
            end
            if (4 * QUADS * W < VL) begin : g_pad
                assign per_w[wi][VL-1:4*QUADS*W] = '0;
            end
        end else begin : g_none
            assign per_w[wi] = '0;
        end
    end

    always_comb begin
        unique case (ew)
            EW_8:    dst = per_w[0];
            EW_16:   dst = per_w[1];
            EW_32:   dst = per_w[2];
            EW_64:   dst = per_w[3];
            EW_128:  dst = per_w[4];
            default: dst = '0;
        endcase
    end
endmodule

// File: rtl/zip4_ctrl.sv
module zip4_ctrl
    import zip4_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic       bad_cfg,
    input  logic       out_ready,
    output logic       in_ready,
    output logic       load,
    output logic       out_valid,
    output logic [1:0] out_idx,
    output logic       out_last,
    output logic       out_illegal
);
    zip_state_e state, state_nx;
    logic [1:0] idx, idx_nx;
    logic       take;

    assign take = out_valid && out_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            idx   <= '0;
        end else begin
            state <= state_nx;
            idx   <= idx_nx;
        end
    end

    always_comb begin
        state_nx = state;
        idx_nx   = idx;
        unique case (state)
            ST_IDLE: begin
                idx_nx = '0;
                if (in_valid) state_nx = bad_cfg ? ST_FAULT : ST_SEND;
            end
            ST_SEND: begin
                if (take) begin
                    idx_nx = idx + 2'd1;
                    if (idx == 2'd3) state_nx = ST_IDLE;
                end
            end
            ST_FAULT: begin
                if (take) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        in_ready    = 1'b0;
        out_valid   = 1'b0;
        out_last    = 1'b0;
        out_illegal = 1'b0;
        out_idx     = idx;
        unique case (state)
            ST_IDLE:  in_ready = 1'b1;
            ST_SEND: begin
                out_valid = 1'b1;
                out_last  = (idx == 2'd3);
            end
            ST_FAULT: begin
                out_valid   = 1'b1;
                out_last    = 1'b1;
                out_illegal = 1'b1;
            end
            default: ;
        endcase
    end

    assign load = in_valid && in_ready;

    // R6: never ready while a beat is pending
    a_r6_ready_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid));

    // R3: data beats advance by one index after each hand-over
    a_r3_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !out_last) |=> (out_valid && out_idx == $past(out_idx) + 2'd1));

    // R3: last data beat carries index 3
    a_r3_last_idx: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_last && !out_illegal) |-> (out_idx == 2'd3));

    // R4: an error beat is always final
    a_r4_err_last: assert property (@(posedge clk) disable iff (!rst_n)
        out_illegal |-> (out_last && out_valid));

    // R6: accept of a legal op leads to data beat 0
    a_r6_accept_send: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !bad_cfg) |=> (out_valid && !out_illegal && out_idx == 2'd0));
endmodule

// File: rtl/vec_zip4.sv
module vec_zip4
    import zip4_pkg::*;
#(
    parameter int VL     = 512,
    parameter int MAX_VL = 2048
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [1:0]    in_size,
    input  logic          in_wide,
    input  logic [VL-1:0] in_src0,
    input  logic [VL-1:0] in_src1,
    input  logic [VL-1:0] in_src2,
    input  logic [VL-1:0] in_src3,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [VL-1:0] out_data,
    output logic [1:0]    out_idx,
    output logic          out_last,
    output logic          out_illegal
);
    ew_code_e      ew_in, ew_q;
    logic          bad_cfg, load;
    logic [VL-1:0] s0_q, s1_q, s2_q, s3_q;
    logic [VL-1:0] perm;

    assign ew_in   = in_wide ? EW_128 : ew_code_e'({1'b0, in_size});
    assign bad_cfg = ew_illegal(ew_in, VL, MAX_VL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ew_q <= EW_8;
            s0_q <= '0;
            s1_q <= '0;
            s2_q <= '0;
            s3_q <= '0;
        end else if (load) begin
            ew_q <= ew_in;
            s0_q <= in_src0;
            s1_q <= in_src1;
            s2_q <= in_src2;
            s3_q <= in_src3;
        end
    end

    zip4_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .bad_cfg    (bad_cfg),
        .out_ready  (out_ready),
        .in_ready   (in_ready),
        .load       (load),
        .out_valid  (out_valid),
        .out_idx    (out_idx),
        .out_last   (out_last),
        .out_illegal(out_illegal)
    );

    zip4_permute #(.VL(VL)) u_perm (
        .src0   (s0_q),
        .src1   (s1_q),
        .src2   (s2_q),
        .src3   (s3_q),
        .ew     (ew_q),
        .dst_idx(out_idx),
        .dst    (perm)
    );

    assign out_data = (out_valid && !out_illegal) ? perm : '0;

    // R7: pending beat held while stalled
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_data) && $stable(out_idx)
             && $stable(out_last) && $stable(out_illegal)));

    // R4: error beat carries no data
    a_r4_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
        out_illegal |-> (out_data == '0));

    // R5: rejected configuration accepted leads to the error beat
    a_r5_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (load && bad_cfg) |=> (out_valid && out_illegal));
endmodule

// File: tb/sim_vec_zip4.sv
module sim_vec_zip4;
    localparam int VL     = 128;
    localparam int MAX_VL = 128;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [1:0]    in_size = '0;
    logic          in_wide = 1'b0;
    logic [VL-1:0] in_src0 = '0, in_src1 = '0, in_src2 = '0, in_src3 = '0;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [VL-1:0] out_data;
    logic [1:0]    out_idx;
    logic          out_last;
    logic          out_illegal;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    logic [VL-1:0] sv [4];

    always #10 clk = ~clk;

    vec_zip4 #(.VL(VL), .MAX_VL(MAX_VL)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_size(in_size), .in_wide(in_wide),
        .in_src0(in_src0), .in_src1(in_src1), .in_src2(in_src2), .in_src3(in_src3),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_idx(out_idx), .out_last(out_last), .out_illegal(out_illegal)
    );

    task automatic chk(input bit ok, input string req, input logic [VL-1:0] act,
                       input logic [VL-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            total++;
            bad++;
            $display("FAIL watchdog act=%0d exp=%0d", cyc, 100000);
            finish_run();
        end
    end

    function automatic logic [VL-1:0] expd(int r, int esz);
        logic [VL-1:0] d;
        int quads = VL / (4 * esz);
        for (int b = 0; b < VL; b++) begin
            int j  = b / esz;
            int bt = b % esz;
            int q  = j / 4;
            int k  = j % 4;
            d[b] = sv[k][(r * quads + q) * esz + bt];
        end
        return d;
    endfunction

    function automatic logic [VL-1:0] mkpat(int pat, int k);
        logic [VL-1:0] v;
        for (int w = 0; w < VL / 32; w++) v[w*32 +: 32] = $urandom;
        if (pat == 0) for (int j = 0; j < VL / 8; j++) v[j*8 +: 8] = 8'(k * 64 + j);
        if (pat == 1) v = VL'(1) << ((k * 37 + 5) % VL);
        return v;
    endfunction

    task automatic do_op(input int sz, input int wd, input int pat, input bit stall);
        int  esz;
        bit  ill;
        int  nb;
        logic [VL-1:0] snap_d;
        logic [3:0]    snap_c;
        esz = wd ? 128 : (8 << sz);
        ill = (VL < 4 * esz) || (!wd && sz == 3 && MAX_VL < 256) || (wd && MAX_VL < 512);
        nb  = ill ? 1 : 4;
        @(negedge clk);
        for (int k = 0; k < 4; k++) sv[k] = mkpat(pat, k);
        in_src0 = sv[0]; in_src1 = sv[1]; in_src2 = sv[2]; in_src3 = sv[3];
        in_size = 2'(sz); in_wide = 1'(wd); in_valid = 1'b1;
        chk(in_ready == 1'b1, "R6 ready before accept", VL'(in_ready), VL'(1));
        @(negedge clk);
        in_valid = 1'b0;
        // R8: scramble inputs after acceptance
        in_src0 = ~sv[0]; in_src1 = ~sv[1]; in_src2 = ~sv[2]; in_src3 = ~sv[3];
        in_size = ~in_size; in_wide = ~in_wide;
        for (int b = 0; b < nb; b++) begin
            if (stall) begin
                snap_d = out_data;
                snap_c = {out_valid, out_last, out_illegal, out_idx[0]};
                @(negedge clk);
                chk(out_data == snap_d && snap_c == {out_valid, out_last, out_illegal, out_idx[0]},
                    "R7 hold", out_data, snap_d);
            end
            chk(out_valid == 1'b1, "R3 valid", VL'(out_valid), VL'(1));
            chk(out_illegal == ill, ill ? "R4/R5 flag" : "R1 legal flag", VL'(out_illegal), VL'(ill));
            chk(out_last == (b == nb - 1), "R3 last", VL'(out_last), VL'(b == nb - 1));
            if (!ill) chk(out_idx == 2'(b), "R3 idx", VL'(out_idx), VL'(b));
            chk(out_data == (ill ? '0 : expd(b, esz)), ill ? "R4 zero data" : "R1/R2/R8 data",
                out_data, ill ? '0 : expd(b, esz));
            chk(in_ready == 1'b0, "R6 busy", VL'(in_ready), VL'(0));
            out_ready = 1'b1;
            @(negedge clk);
            out_ready = 1'b0;
        end
        chk(out_valid == 1'b0, "R3/R4 no extra beat", VL'(out_valid), VL'(0));
        chk(in_ready == 1'b1, "R6 ready after last", VL'(in_ready), VL'(1));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R9 out_valid", VL'(out_valid), VL'(0));
        chk(in_ready == 1'b1, "R9 in_ready", VL'(in_ready), VL'(1));
        // R6: no accept without in_valid
        @(negedge clk);
        chk(out_valid == 1'b0, "R6 idle no accept", VL'(out_valid), VL'(0));
        for (int wd = 0; wd < 2; wd++)
            for (int sz = 0; sz < 4; sz++)
                for (int pat = 0; pat < 3; pat++)
                    do_op(sz, wd, pat, ((sz + pat) % 2) == 1);
        finish_run();
    end
endmodule